// File: doc/BRIEF.md
# Parallel flash identification probe

This block runs the identification probe of a parallel NOR flash on its asynchronous byte bus. After a single start pulse it sends the three-cycle unlock-and-identify command. It waits the configured settling time and then reads the manufacturer code and the device code. A code byte of 0x7F counts as a continuation marker: the block fetches one further byte and forms a 16-bit code from the two. Next it sends the three-cycle command that returns the device to array mode. It reads the same locations again as ordinary array data, still following the continuation rule.

When the probe ends, the block presents both assembled codes and three diagnostic flags. One flag reports an odd-parity failure on the final manufacturer byte read. The other two report, for each code, that it is identical to the array content read afterwards. That case means the device probably never entered identification mode. A separate flag is set when both codes equal the expected values on the input ports. A microsecond prescaler times all settling delays. The timing setting can give an explicit delay, ask for no delay, ask for the defaults, or ask for an immediate abort.

No data stream passes through the block, so it has no valid/ready handshake. Control is a start pulse, with a busy level and a one-cycle done pulse in return. The bus is free-running. A write is a one-cycle `bus_we` strobe. A read is a one-cycle `bus_re` strobe, and `bus_rdata` is sampled at the clock edge that ends that cycle.

Top module: `flash_id_probe`

## Requirements
- R1: The entry command is three write strobes in this exact order: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555.
- R2: The exit command is three write strobes in this exact order: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xF0 to 0x5555. It follows the last identification read.
- R3: Let D be the phase delay in microseconds and C be CLKS_PER_US. After the first and second write of a command, the next bus strobe comes 10·C+2 cycles after the write strobe. After the third write, it comes D·C+2 cycles after the write strobe. When D is 0, every one of these gaps is exactly 1 cycle.
- R4: timing_mode encoding: 0 means explicit, where timing_us is D for both entry and exit. 1 means zero, where no delays are inserted at all.
- R5: timing_mode 2 means default: D is 10000 µs for entry and 40 µs for exit.
- R6: timing_mode 3 means abort. In the cycle after start, done and aborted are both 1 with busy 0, and the bus shows no strobe at all.
- R7: Reads in each pass go to 0x000 and then 0x001. A read of 0x100 follows only when the byte read at 0x000 was 0x7F. A read of 0x101 follows only when the byte read at 0x001 was 0x7F. A code is {first, second} when first is 0x7F, and {0x00, first} otherwise.
- R8: parity_err is 1 when the final manufacturer byte read in identification mode has an even number of ones. That byte is the continuation byte when one was read.
- R9: mfr_is_array and dev_is_array are 1 when the corresponding identification code equals the code assembled from the post-exit array reads.
- R10: id_match is 1 only when mfr_id equals exp_mfr and dev_id equals exp_dev.
- R11: done is a one-cycle pulse. busy goes high in the cycle after an accepted start. start is ignored while busy. A write and a read strobe never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-probe pulse, taken only when idle |
| timing_mode | input | 2 | 0 explicit, 1 zero, 2 default, 3 abort |
| timing_us | input | UW | Explicit delay in µs (mode 0) |
| exp_mfr | input | 16 | Expected manufacturer code |
| exp_dev | input | 16 | Expected device code |
| bus_addr | output | AW | Flash byte address |
| bus_wdata | output | 8 | Write data to flash |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, sampled at the end of a read strobe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last probe aborted without bus access |
| mfr_id | output | 16 | Assembled manufacturer code |
| dev_id | output | 16 | Assembled device code |
| id_match | output | 1 | Both codes equal the expected values |
| parity_err | output | 1 | Final manufacturer byte has even parity |
| mfr_is_array | output | 1 | Manufacturer code equals array content |
| dev_is_array | output | 1 | Device code equals array content |

## Verification
The assertions check a set of bus rules on every cycle. Writes and reads are never simultaneous. Writes go only to the two unlock addresses and carry only the four command codes, and the identify code goes only to 0x5555. Reads go only to the four identification offsets. The bus stays quiet while the block is idle. They also check the abort response and the done and busy timing. The bench scenarios are the only check on the exact order of the whole strobe sequence and on the cycle gaps for each timing mode. They also cover when continuation reads happen, the code assembly, the parity rule, the array cross-check and the match result, under device contents drawn at random and chosen by hand.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_WAIT,
    S_RD,
    S_FIN
  } probe_state_t;

  localparam logic [1:0] TM_GIVEN   = 2'd0;
  localparam logic [1:0] TM_ZERO    = 2'd1;
  localparam logic [1:0] TM_DEFAULT = 2'd2;
  localparam logic [1:0] TM_ABORT   = 2'd3;

  localparam logic [7:0] CONT_CODE   = 8'h7F;
  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_ID_ON   = 8'h90;
  localparam logic [7:0] CMD_ID_OFF  = 8'hF0;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

  // address of command cycle idx (0..2)
  function automatic logic [15:0] cmd_addr(input logic [1:0] idx);
    return (idx == 2'd1) ? KEY_ADDR_B : KEY_ADDR_A;
  endfunction

  // data of command cycle idx; the third cycle selects entry or exit
  function automatic logic [7:0] cmd_data(input logic exit_seq, input logic [1:0] idx);
    case (idx)
      2'd0:    return CMD_KEY_A;
      2'd1:    return CMD_KEY_B;
      default: return exit_seq ? CMD_ID_OFF : CMD_ID_ON;
    endcase
  endfunction

  // read slot: 0/1 are the base codes, 2/3 their continuation bytes
  function automatic logic [15:0] slot_addr(input logic [1:0] idx);
    case (idx)
      2'd0:    return 16'h0000;
      2'd1:    return 16'h0001;
      2'd2:    return 16'h0100;
      default: return 16'h0101;
    endcase
  endfunction

endpackage

// File: rtl/probe_us_timer.sv
module probe_us_timer #(
  parameter int CLKS_PER_US = 4,
  parameter int UW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] load_us,
  output logic          expired
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] pre;
  logic [UW-1:0] left;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      left    <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        pre  <= '0;
        left <= load_us;
        run  <= (load_us != '0);
      end else if (run) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          if (left == UW'(1)) begin
            run     <= 1'b0;
            expired <= 1'b1;
          end else begin
            left <= left - UW'(1);
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/probe_id_join.sv
module probe_id_join
  import flash_probe_pkg::*;
(
  input  logic [7:0]  first_byte,
  input  logic [7:0]  cont_byte,
  output logic [15:0] code
);
  always_comb begin
    if (first_byte == CONT_CODE) code = {first_byte, cont_byte};
    else                         code = {8'h00, first_byte};
  end
endmodule

// File: rtl/probe_id_check.sv
module probe_id_check (
  input  logic [15:0] id_mfr,
  input  logic [15:0] id_dev,
  input  logic [15:0] arr_mfr,
  input  logic [15:0] arr_dev,
  input  logic [7:0]  mfr_last,
  input  logic [15:0] want_mfr,
  input  logic [15:0] want_dev,
  output logic        both_match,
  output logic        even_parity,
  output logic        mfr_same,
  output logic        dev_same
);
  always_comb begin
    both_match  = (id_mfr == want_mfr) && (id_dev == want_dev);
    even_parity = ~(^mfr_last);
    mfr_same    = (id_mfr == arr_mfr);
    dev_same    = (id_dev == arr_dev);
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int CLKS_PER_US  = 4,
  parameter int AW           = 16,
  parameter int UW           = 16,
  parameter int SHORT_US     = 10,
  parameter int DEF_ENTER_US = 10000,
  parameter int DEF_EXIT_US  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    timing_mode,
  input  logic [UW-1:0] timing_us,
  input  logic [15:0]   exp_mfr,
  input  logic [15:0]   exp_dev,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          aborted,
  output logic [15:0]   mfr_id,
  output logic [15:0]   dev_id,
  output logic          id_match,
  output logic          parity_err,
  output logic          mfr_is_array,
  output logic          dev_is_array
);
  localparam int NPASS = 2;
  localparam int NSLOT = 4;

  probe_state_t  state;
  logic          seq_exit;
  logic          pass;
  logic [1:0]    cidx;
  logic [1:0]    ridx;
  logic [UW-1:0] enter_us, exit_us;
  logic [UW-1:0] long_us, dly_us;
  logic          tmr_expired;
  logic          rd_en;
  logic [7:0]    cap [NPASS][NSLOT];
  logic [15:0]   code [NPASS][2];
  logic [7:0]    mfr_last;
  logic          c_match, c_par, c_msame, c_dsame;

  // delay owed after the current write
  always_comb begin
    long_us = seq_exit ? exit_us : enter_us;
    if (cidx == 2'd2)        dly_us = long_us;
    else if (long_us != '0)  dly_us = UW'(SHORT_US);
    else                     dly_us = '0;
  end

  // continuation slots read only when the base byte was the marker
  always_comb rd_en = (state == S_RD) && (!ridx[1] || (cap[pass][ridx[0]] == CONT_CODE));

  always_comb begin
    bus_we    = (state == S_WR);
    bus_re    = rd_en;
    bus_wdata = (state == S_WR) ? cmd_data(seq_exit, cidx) : 8'h00;
    if (state == S_WR)      bus_addr = AW'(cmd_addr(cidx));
    else if (state == S_RD) bus_addr = AW'(slot_addr(ridx));
    else                    bus_addr = '0;
  end

  assign busy = (state != S_IDLE);

  probe_us_timer #(.CLKS_PER_US(CLKS_PER_US), .UW(UW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    ((state == S_WR) && (dly_us != '0)),
    .load_us (dly_us),
    .expired (tmr_expired)
  );

  for (genvar p = 0; p < NPASS; p++) begin : g_pass
    for (genvar w = 0; w < 2; w++) begin : g_code
      probe_id_join i_join (
        .first_byte (cap[p][w]),
        .cont_byte  (cap[p][w+2]),
        .code       (code[p][w])
      );
    end
  end

  assign mfr_last = (cap[0][0] == CONT_CODE) ? cap[0][2] : cap[0][0];

  probe_id_check i_check (
    .id_mfr      (code[0][0]),
    .id_dev      (code[0][1]),
    .arr_mfr     (code[1][0]),
    .arr_dev     (code[1][1]),
    .mfr_last    (mfr_last),
    .want_mfr    (exp_mfr),
    .want_dev    (exp_dev),
    .both_match  (c_match),
    .even_parity (c_par),
    .mfr_same    (c_msame),
    .dev_same    (c_dsame)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPASS; p++)
        for (int s = 0; s < NSLOT; s++) cap[p][s] <= 8'h00;
    end else if (rd_en) begin
      cap[pass][ridx] <= bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      seq_exit     <= 1'b0;
      pass         <= 1'b0;
      cidx         <= 2'd0;
      ridx         <= 2'd0;
      enter_us     <= '0;
      exit_us      <= '0;
      done         <= 1'b0;
      aborted      <= 1'b0;
      mfr_id       <= '0;
      dev_id       <= '0;
      id_match     <= 1'b0;
      parity_err   <= 1'b0;
      mfr_is_array <= 1'b0;
      dev_is_array <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (timing_mode == TM_ABORT) begin
            done         <= 1'b1;
            aborted      <= 1'b1;
            mfr_id       <= '0;
            dev_id       <= '0;
            id_match     <= 1'b0;
            parity_err   <= 1'b0;
            mfr_is_array <= 1'b0;
            dev_is_array <= 1'b0;
          end else begin
            aborted  <= 1'b0;
            seq_exit <= 1'b0;
            cidx     <= 2'd0;
            state    <= S_WR;
            case (timing_mode)
              TM_GIVEN: begin enter_us <= timing_us; exit_us <= timing_us; end
              TM_ZERO:  begin enter_us <= '0;        exit_us <= '0;        end
              default:  begin enter_us <= UW'(DEF_ENTER_US); exit_us <= UW'(DEF_EXIT_US); end
            endcase
          end
        end
        S_WR, S_WAIT: begin
          if ((state == S_WR && dly_us != '0)) begin
            state <= S_WAIT;
          end else if (state == S_WR || tmr_expired) begin
            if (cidx != 2'd2) begin
              cidx  <= cidx + 2'd1;
              state <= S_WR;
            end else begin
              ridx  <= 2'd0;
              pass  <= seq_exit;
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          ridx <= ridx + 2'd1;
          if (ridx == 2'd3) begin
            if (!pass) begin
              seq_exit <= 1'b1;
              cidx     <= 2'd0;
              state    <= S_WR;
            end else begin
              state <= S_FIN;
            end
          end
        end
        S_FIN: begin
          mfr_id       <= code[0][0];
          dev_id       <= code[0][1];
          id_match     <= c_match;
          parity_err   <= c_par;
          mfr_is_array <= c_msame;
          dev_is_array <= c_dsame;
          done         <= 1'b1;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    timing_mode,
  input logic          busy,
  input logic          done,
  input logic          aborted,
  input logic          bus_we,
  input logic          bus_re,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_re)); // R6

  AST_CMD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_addr == AW'(16'h5555) || bus_addr == AW'(16'h2AAA))); // R1

  AST_ID_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata == 8'h90) |-> bus_addr == AW'(16'h5555)); // R1

  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_wdata == 8'hAA || bus_wdata == 8'h55 ||
                bus_wdata == 8'h90 || bus_wdata == 8'hF0)); // R2

  AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |-> (bus_addr == AW'(0) || bus_addr == AW'(1) ||
                bus_addr == AW'(16'h0100) || bus_addr == AW'(16'h0101))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_ABORT_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && timing_mode == 2'd3) |=> (done && aborted && !busy)); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && timing_mode != 2'd3) |=> busy); // R11
endmodule

bind flash_id_probe flash_id_probe_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .timing_mode (timing_mode),
  .busy        (busy),
  .done        (done),
  .aborted     (aborted),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int AW = 16;
  localparam int UW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] timing_mode = 2'd0;
  logic [UW-1:0] timing_us = '0;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, busy, done, aborted;
  logic [15:0] mfr_id, dev_id;
  logic id_match, parity_err, mfr_is_array, dev_is_array;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_id_probe #(.CLKS_PER_US(CPU), .AW(AW), .UW(UW)) i_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .timing_mode(timing_mode),
    .timing_us(timing_us), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .aborted(aborted),
    .mfr_id(mfr_id), .dev_id(dev_id), .id_match(id_match), .parity_err(parity_err),
    .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array));

  // device model
  logic [7:0] m0, m1, d0, d1, a0, a1, a100, a101;
  logic id_mode, log_clr = 1'b0;
  int cyc = 0, ev_n = 0;
  logic ev_we [32];
  logic [AW-1:0] ev_addr [32];
  logic [7:0] ev_data [32];
  int ev_cyc [32];

  always_comb begin
    case (bus_addr)
      16'h0000: bus_rdata = id_mode ? m0 : a0;
      16'h0001: bus_rdata = id_mode ? d0 : a1;
      16'h0100: bus_rdata = id_mode ? m1 : a100;
      16'h0101: bus_rdata = id_mode ? d1 : a101;
      default:  bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (log_clr) begin
      ev_n <= 0;
      id_mode <= 1'b0;
    end else begin
      if (bus_we || bus_re) begin
        if (ev_n < 32) begin
          ev_we[ev_n] <= bus_we; ev_addr[ev_n] <= bus_addr;
          ev_data[ev_n] <= bus_wdata; ev_cyc[ev_n] <= cyc;
        end
        ev_n <= ev_n + 1;
      end
      if (bus_we && bus_wdata == 8'h90) id_mode <= 1'b1;
      if (bus_we && bus_wdata == 8'hF0) id_mode <= 1'b0;
    end
  end

  // expected event list
  int x_n;
  logic x_we [32];
  logic [AW-1:0] x_addr [32];
  logic [7:0] x_data [32];
  int x_gap [32];

  task automatic push(input logic we, input logic [15:0] a, input logic [7:0] d, input int gap);
    x_we[x_n] = we; x_addr[x_n] = AW'(a); x_data[x_n] = d; x_gap[x_n] = gap;
    x_n++;
  endtask

  function automatic int gap_of(input int us);
    return (us == 0) ? 1 : us * CPU + 2;
  endfunction

  function automatic logic [15:0] join_id(input logic [7:0] f, input logic [7:0] s);
    return (f == 8'h7F) ? {f, s} : {8'h00, f};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_cmd(input logic ex, input int long_us);
    int s = (long_us == 0) ? 0 : 10;
    push(1, 16'h5555, 8'hAA, -1);
    push(1, 16'h2AAA, 8'h55, gap_of(s));
    push(1, 16'h5555, ex ? 8'hF0 : 8'h90, gap_of(s));
  endtask

  task automatic push_rd(input logic [7:0] b0, input logic [7:0] b1, input int g);
    push(0, 16'h0000, 8'h00, g);
    push(0, 16'h0001, 8'h00, 1);
    if (b0 == 8'h7F) push(0, 16'h0100, 8'h00, -1);
    if (b1 == 8'h7F) push(0, 16'h0101, 8'h00, -1);
  endtask

  task automatic run_probe(input logic [1:0] mode, input int us, input logic restart);
    int en_us, ex_us, waited;
    logic [15:0] em, ed, am, ad;
    logic [7:0] last;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    timing_mode = mode; timing_us = UW'(us);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mode == 2'd3) begin
      chk(done && aborted && !busy, "R6 abort done/aborted", {done, aborted, busy}, 3'b110);
      @(negedge clk);
      chk(ev_n == 0, "R6 no bus access on abort", ev_n, 0);
      chk(!done, "R11 done single pulse", done, 0);
      return;
    end
    chk(busy, "R11 busy after start", busy, 1);
    if (restart) begin
      repeat (4) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 60000) begin @(negedge clk); waited++; end
    if (!done) begin
      chk(0, "R11 watchdog: probe never finished", waited, 0);
      return;
    end
    chk(!busy, "R11 idle at done", busy, 0);
    en_us = (mode == 2'd0) ? us : (mode == 2'd1) ? 0 : 10000;
    ex_us = (mode == 2'd0) ? us : (mode == 2'd1) ? 0 : 40;
    x_n = 0;
    push_cmd(0, en_us); push_rd(m0, d0, gap_of(en_us));
    push_cmd(1, ex_us); push_rd(a0, a1, gap_of(ex_us));
    chk(ev_n == x_n, "R7 bus strobe count", ev_n, x_n);
    for (int k = 0; k < x_n && k < ev_n; k++) begin
      chk(ev_we[k] == x_we[k] && ev_addr[k] == x_addr[k], k < 10 ? "R1 R7 strobe kind/address" : "R2 R9 strobe kind/address",
          {ev_we[k], ev_addr[k]}, {x_we[k], x_addr[k]});
      if (x_we[k]) chk(ev_data[k] == x_data[k], "R1 R2 command data", ev_data[k], x_data[k]);
      if (x_gap[k] >= 0 && k > 0)
        chk(ev_cyc[k] - ev_cyc[k-1] == x_gap[k], mode == 2'd2 ? "R5 default delay gap" :
            mode == 2'd1 ? "R4 zero-delay gap" : "R3 delay gap", ev_cyc[k] - ev_cyc[k-1], x_gap[k]);
    end
    em = join_id(m0, m1); ed = join_id(d0, d1);
    am = join_id(a0, a100); ad = join_id(a1, a101);
    last = (m0 == 8'h7F) ? m1 : m0;
    chk(mfr_id == em, "R7 manufacturer code", mfr_id, em);
    chk(dev_id == ed, "R7 device code", dev_id, ed);
    chk(parity_err == ~(^last), "R8 parity flag", parity_err, ~(^last));
    chk(mfr_is_array == (em == am), "R9 manufacturer array flag", mfr_is_array, em == am);
    chk(dev_is_array == (ed == ad), "R9 device array flag", dev_is_array, ed == ad);
    chk(id_match == (em == exp_mfr && ed == exp_dev), "R10 match flag", id_match, em == exp_mfr && ed == exp_dev);
    chk(!aborted, "R6 aborted clear on normal run", aborted, 0);
    @(negedge clk);
    chk(!done, "R11 done single pulse", done, 0);
  endtask

  function automatic logic [7:0] rbyte();
    return ($urandom_range(3) == 0) ? 8'h7F : 8'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd4711));
    m0 = 0; m1 = 0; d0 = 0; d1 = 0; a0 = 0; a1 = 0; a100 = 0; a101 = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_we && !bus_re, "R11 reset state", {busy, done, bus_we, bus_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // explicit delay, manufacturer continuation, matching, odd parity byte
    m0 = 8'h7F; m1 = 8'h01; d0 = 8'h22; d1 = 8'h00;
    a0 = 8'hFF; a1 = 8'hFF; a100 = 8'hFF; a101 = 8'hFF;
    exp_mfr = 16'h7F01; exp_dev = 16'h0022;
    run_probe(2'd0, 3, 1'b0);

    // zero delay, both continuations, mismatch, even-parity byte, start while busy
    m0 = 8'h7F; m1 = 8'h03; d0 = 8'h7F; d1 = 8'h7F;
    exp_mfr = 16'h7F03; exp_dev = 16'h1234;
    run_probe(2'd1, 0, 1'b1);

    // explicit value 0 behaves like zero mode; device not in ID mode (array equals ID)
    m0 = 8'h20; d0 = 8'h7F; d1 = 8'h44;
    a0 = 8'h20; a1 = 8'h7F; a101 = 8'h44;
    exp_mfr = 16'h0020; exp_dev = 16'h7F44;
    run_probe(2'd0, 0, 1'b0);

    // abort mode
    run_probe(2'd3, 5, 1'b0);

    // default timings
    m0 = 8'h1F; d0 = 8'hA4; a0 = 8'h00; a1 = 8'h00;
    exp_mfr = 16'h001F; exp_dev = 16'h00A4;
    run_probe(2'd2, 0, 1'b0);

    // random contents
    for (int it = 0; it < 8; it++) begin
      m0 = rbyte(); m1 = rbyte(); d0 = rbyte(); d1 = rbyte();
      a0 = ($urandom_range(1) == 0) ? m0 : rbyte(); a100 = m1;
      a1 = rbyte(); a101 = rbyte();
      exp_mfr = ($urandom_range(1) == 0) ? join_id(m0, m1) : 16'($urandom);
      exp_dev = ($urandom_range(1) == 0) ? join_id(d0, d1) : 16'($urandom);
      run_probe(($urandom_range(1) == 0) ? 2'd0 : 2'd1, $urandom_range(6), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL R11: global watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule